// File: doc/BRIEF.md
# Backlight PWM Generator

This block produces one pulse-width-modulated output for dimming a display backlight. A free-running 8-bit counter advances once per prescaled tick. The output is active while the count is below a compare value, so the duty steps in 1/256 increments from 0/256 up to 255/256. A 3-bit prescale setting p stretches every count to 2^p source ticks, for p from 0 to 6.

The counting source is either the system clock itself or a slow clock. Both are modelled as a clock-enable pulse inside the single system clock domain. The slow tick is one system cycle in every `SLOW_DIV`.

Software writes a 16-bit configuration word and sets the source-select level. It starts and stops the output with one-cycle enable and disable strobes, then polls a running status bit. That bit follows a strobe only after a fixed delay counted in source ticks. Configuration changes made while the output runs are held in a shadow copy and take effect at the next period boundary. The block has no data stream: every pin is a plain control or status level, so it has no valid/ready handshake and no back-pressure.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset, `running` is 0 and `pwm_out` is 0. The configuration is compare 0, normal polarity and prescale 0.
- R2: A configuration write takes compare from bits 15:8, polarity from bit 4 (1 = normal, 0 = inverted) and prescale from bits 2:0. A write whose prescale field is 7 is ignored as a whole, and the previous configuration stays in force.
- R3: One output period lasts 256 × 2^p source ticks. With normal polarity and compare value c, the output is high for the first c × 2^p ticks of the period and low for the rest.
- R4: Compare 255 gives an output that is low for exactly one count per period. Compare 0 gives an output that is never high, so the duty spans 0/256 to 255/256.
- R5: With inverted polarity the output is the complement of the normal-polarity waveform, so compare c gives (256 − c) × 2^p high ticks per period.
- R6: With `src_sel_fast` = 1, every system clock cycle is a source tick. With `src_sel_fast` = 0, one cycle in every `SLOW_DIV` is a source tick, so all periods and the status delay stretch by that factor.
- R7: An `en_stb` pulse requests the running state and a `dis_stb` pulse requests the stopped state. When both pulse in the same cycle, the stop request wins.
- R8: `running` takes the requested state at the second source tick after the strobe is sampled. With the fast source, a strobe sampled at clock edge N is seen on `running` after edge N+2.
- R9: While stopped, the counter is held at zero and `pwm_out` sits at its inactive level: low for normal polarity, high for inverted. After a start, the first period begins at count zero.
- R10: A configuration written while running is applied only at the next wrap of the counter from 255 to 0, so the period in progress finishes with the old values. A configuration written while stopped takes effect before the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel_fast | input | 1 | 1 = count on every system clock, 0 = count on the slow tick |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word: compare 15:8, polarity 4, prescale 2:0 |
| en_stb | input | 1 | Write-one start request |
| dis_stb | input | 1 | Write-one stop request |
| running | output | 1 | Status: the PWM is running |
| pwm_out | output | 1 | PWM output |

## Verification
The bench measures whole periods starting at the first running cycle and compares the count of high cycles with the value the requirements predict. This catches an off-by-one prescale limit, a counter that does not restart at zero, and a compare that drops or adds a count at 255 or 0. A compare value rewritten in the middle of a period exposes a design that applies it at once: the first measured period would show more high cycles than the old value allows.

The bench counts the edges from a strobe to the status change, which catches a handshake that is a stage short or long. It fires both strobes in the same cycle, where a design that favours enable would start running. A write with prescale 7 followed by a start shows whether an illegal setting leaked into the configuration. A run on the slow source checks that the clock-enable gates every counting stage.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int CMP_W  = 8;       // compare and counter width
  localparam int PS_W   = 3;       // prescale field width
  localparam int PS_MAX = 6;       // largest legal prescale
  localparam int PRE_W  = PS_MAX;  // prescale counter width (up to 2^6-1)

  typedef struct packed {
    logic [CMP_W-1:0] cmp;
    logic             pol_normal;
    logic [PS_W-1:0]  ps;
  } pwm_cfg_t;

  localparam pwm_cfg_t CFG_RESET = '{cmp: '0, pol_normal: 1'b1, ps: '0};
endpackage

// File: rtl/bl_pwm_clksrc.sv
module bl_pwm_clksrc #(
  parameter int SLOW_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_fast,
  output logic tick
);
  logic slow_pulse;

  generate
    if (SLOW_DIV <= 1) begin : g_nodiv
      assign slow_pulse = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(SLOW_DIV);
      localparam logic [DW-1:0] LAST = DW'(SLOW_DIV - 1);
      logic [DW-1:0] div_q;

      always_ff @(posedge clk) begin
        if (!rst_n)              div_q <= '0;
        else if (div_q == LAST)  div_q <= '0;
        else                     div_q <= div_q + 1'b1;
      end
      assign slow_pulse = (div_q == LAST);

      p_slow_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        slow_pulse |=> !slow_pulse);
    end
  endgenerate

  assign tick = sel_fast | slow_pulse;
endmodule

// File: rtl/bl_pwm_handshake.sv
module bl_pwm_handshake #(
  parameter int DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en_stb,
  input  logic dis_stb,
  output logic running
);
  logic             req_q;
  logic [DELAY-1:0] stg_q;

  // stop wins over start when both arrive together
  always_ff @(posedge clk) begin
    if (!rst_n)       req_q <= 1'b0;
    else if (dis_stb) req_q <= 1'b0;
    else if (en_stb)  req_q <= 1'b1;
  end

  for (genvar i = 0; i < DELAY; i++) begin : g_stage
    logic d;
    if (i == 0) begin : g_first
      assign d = req_q;
    end else begin : g_next
      assign d = stg_q[i-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)    stg_q[i] <= 1'b0;
      else if (tick) stg_q[i] <= d;
    end
  end

  assign running = stg_q[DELAY-1];

  p_status_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running != $past(running)) |-> $past(tick));

  p_stop_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dis_stb |=> !req_q);
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
  import bl_pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     run,
  input  pwm_cfg_t cfg,
  output logic     pwm_out
);
  pwm_cfg_t         sh_q;
  logic [CMP_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_lim;
  logic             step, wrap, active;

  // limit = 2^ps - 1, built as a thermometer mask
  always_comb begin
    for (int b = 0; b < PRE_W; b++) pre_lim[b] = (b < int'(sh_q.ps));
  end

  assign step = run && tick && (pre_q == pre_lim);
  assign wrap = step && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
      pre_q <= '0;
    end else if (tick) begin
      pre_q <= pre_q + 1'b1;
    end
  end

  // shadow follows live config while stopped, reloads only at a wrap while running
  always_ff @(posedge clk) begin
    if (!rst_n)              sh_q <= CFG_RESET;
    else if (!run || wrap)   sh_q <= cfg;
  end

  assign active  = run && (cnt_q < sh_q.cmp);
  assign pwm_out = sh_q.pol_normal ? active : !active;

  p_hold_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0 && pre_q == '0));

  p_pre_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= pre_lim);

  p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(wrap)) |-> $stable(sh_q));
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
  import bl_pwm_pkg::*;
#(
  parameter int SLOW_DIV   = 4,
  parameter int STAT_DELAY = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        src_sel_fast,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  input  logic        en_stb,
  input  logic        dis_stb,
  output logic        running,
  output logic        pwm_out
);
  pwm_cfg_t cfg_q, cfg_new;
  logic     tick;
  logic     unused_bits;

  assign cfg_new.cmp        = cfg_wdata[15:8];
  assign cfg_new.pol_normal = cfg_wdata[4];
  assign cfg_new.ps         = cfg_wdata[2:0];
  assign unused_bits        = ^{cfg_wdata[7:5], cfg_wdata[3]};

  always_ff @(posedge clk) begin
    if (!rst_n)                                      cfg_q <= CFG_RESET;
    else if (cfg_we && int'(cfg_new.ps) <= PS_MAX)   cfg_q <= cfg_new;
  end

  bl_pwm_clksrc #(.SLOW_DIV(SLOW_DIV)) u_clksrc (
    .clk(clk), .rst_n(rst_n), .sel_fast(src_sel_fast), .tick(tick));

  bl_pwm_handshake #(.DELAY(STAT_DELAY)) u_hs (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .en_stb(en_stb), .dis_stb(dis_stb), .running(running));

  bl_pwm_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(running),
    .cfg(cfg_q), .pwm_out(pwm_out));

  p_ps_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cfg_q.ps) <= PS_MAX);

  p_bad_write_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[2:0] == 3'd7) |=> $stable(cfg_q));
endmodule

// File: tb/bl_pwm_top_bench.sv
module bl_pwm_top_bench;
  localparam int SD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_sel_fast = 1'b1, cfg_we = 1'b0, en_stb = 1'b0, dis_stb = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic running, pwm_out;

  always #5 clk = ~clk;

  bl_pwm_top #(.SLOW_DIV(SD), .STAT_DELAY(2)) u_bl_pwm_top (
    .clk(clk), .rst_n(rst_n), .src_sel_fast(src_sel_fast), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .en_stb(en_stb), .dis_stb(dis_stb),
    .running(running), .pwm_out(pwm_out));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct { string tag; int len; int exp_hi; } item_t;
  item_t q[$];
  bit busy = 0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // monitor: counts high cycles over each queued window
  initial begin
    item_t cur;
    int left = 0, hi = 0;
    forever begin
      @(negedge clk); #1;
      if (!busy && q.size() > 0) begin
        cur = q.pop_front(); busy = 1; left = cur.len; hi = 0;
      end
      if (busy) begin
        if (pwm_out) hi++;
        left--;
        if (left == 0) begin
          check(cur.tag, hi, cur.exp_hi);
          busy = 0;
        end
      end
    end
  end

  function automatic void expect_period(string tag, int cmp, bit normal, int ps, int div);
    int hi = normal ? (cmp << ps) : ((256 - cmp) << ps);
    q.push_back('{tag, (256 << ps) * div, hi * div});
  endfunction

  task automatic wr_cfg(int cmp, bit normal, int ps);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {cmp[7:0], 3'b000, normal, 1'b0, ps[2:0]};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start(output int k);
    @(negedge clk); en_stb = 1'b1;
    @(negedge clk); en_stb = 1'b0;
    k = 0;
    while (!running && k < 100) begin @(negedge clk); k++; end
  endtask

  task automatic stop(output int k);
    @(negedge clk); dis_stb = 1'b1;
    @(negedge clk); dis_stb = 1'b0;
    k = 0;
    while (running && k < 100) begin @(negedge clk); k++; end
  endtask

  task automatic wait_idle;
    wait (q.size() == 0 && !busy);
    @(negedge clk);
  endtask

  task automatic run_one(string tag, int cmp, bit normal, int ps);
    int k;
    wr_cfg(cmp, normal, ps);
    start(k);
    expect_period(tag, cmp, normal, ps, 1);
    wait_idle();
    stop(k);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int k, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset running", int'(running), 0);
    check("R1 reset pwm_out", int'(pwm_out), 0);

    // R8 latency, R3 period, R10 shadow update mid-period
    wr_cfg(64, 1, 0);
    start(k);
    check("R8 start latency fast", k, 2);
    expect_period("R3 R10 old compare kept in period", 64, 1, 0, 1);
    expect_period("R10 new compare after wrap", 192, 1, 0, 1);
    repeat (100) @(negedge clk);
    wr_cfg(192, 1, 0);
    wait_idle();
    stop(k);
    check("R8 stop latency fast", k, 2);
    bad = 0;
    repeat (20) begin @(negedge clk); if (pwm_out !== 1'b0) bad++; end
    check("R9 stopped normal output low", bad, 0);

    run_one("R4 compare 255", 255, 1, 0);
    run_one("R4 compare 0", 0, 1, 0);
    run_one("R3 prescale 2", 100, 1, 2);
    run_one("R3 prescale 6", 3, 1, 6);
    run_one("R5 inverted", 64, 0, 0);

    wr_cfg(64, 0, 0);
    bad = 0;
    repeat (20) begin @(negedge clk); if (pwm_out !== 1'b1) bad++; end
    check("R9 stopped inverted output high", bad, 0);

    // R2: illegal prescale write is dropped whole
    wr_cfg(40, 1, 0);
    wr_cfg(200, 0, 7);
    start(k);
    expect_period("R2 prescale 7 ignored", 40, 1, 0, 1);
    wait_idle();
    stop(k);

    // R6: slow source
    src_sel_fast = 1'b0;
    wr_cfg(10, 1, 0);
    start(k);
    check("R6 slow start latency in range", int'(k > SD && k <= 2 * SD), 1);
    expect_period("R6 slow period", 10, 1, 0, SD);
    wait_idle();
    stop(k);
    src_sel_fast = 1'b1;
    repeat (4) @(negedge clk);

    // R7: both strobes together
    @(negedge clk); en_stb = 1'b1; dis_stb = 1'b1;
    @(negedge clk); en_stb = 1'b0; dis_stb = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 stop wins over start", int'(running), 0);
    check("R7 output inactive", int'(pwm_out), 0);

    summary();
    $finish;
  end
endmodule